// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block is the host-facing front end of a network controller's register space. It keeps a 16-byte station-address PROM in flops and decodes host accesses that arrive on one of two windows. The first is an I/O window: the lowest sixteen offsets reach the PROM, and every higher offset reaches the controller's register port. The second is a memory window: a single address bit chooses between the PROM and the register port, and the offset is reduced to its low four bits in both cases.

The access sizes allowed in the I/O window depend on an external dword-I/O mode input. When the PROM is reached with an access that breaks the size or alignment rules, the read returns all ones for the width of the access and the write does nothing. An access forwarded to the register port carries its size and data to a generic port, and that port answers in the same cycle. Values wider than one byte are assembled and split in little-endian order. Host read data is combinational and valid in the cycle the read strobe is high. PROM writes take effect at the next rising clock edge, and only when the external PROM write-enable input is high.

Top module: `addr_prom_front`

## Requirements
- R1: When reset ends, PROM byte i holds bits [8i+7:8i] of parameter PROM_INIT, for every i from 0 to 15.
- R2: A PROM write changes the stored bytes only if prom_wr_en is 1 in that cycle. If prom_wr_en is 0, the stored bytes stay unchanged.
- R3: I/O window (host_mem=0) with dword_io=0, offsets 0x00 to 0x0F: a byte access at any offset and a 16-bit access at an even offset reach the PROM. A 16-bit access at an odd offset and a 32-bit access read all ones for the access width and write nothing.
- R4: I/O window with dword_io=1, offsets 0x00 to 0x0F: only a 32-bit access with address bits [1:0]=0 reaches the PROM. A byte, 16-bit or misaligned 32-bit access reads all ones for the access width and writes nothing.
- R5: I/O window, offsets 0x10 and above: a 16-bit or 32-bit access pulses port_rd or port_wr and presents the unchanged address, host_size and host_wdata on the port. Read data is port_rdata masked to the access width. A byte access strobes nothing and reads 0x000000FF.
- R6: Memory window (host_mem=1) with address bit 4 set: a 16-bit or 32-bit access is forwarded with port_addr equal to the address masked to bits [3:0]. A byte access strobes nothing and reads 0x000000FF.
- R7: Memory window with address bit 4 clear: any size at any alignment reaches PROM byte (addr[3:0]+k) mod 16 for byte lane k, so accesses wrap around the end of the PROM.
- R8: Little-endian lanes: the lowest address maps to host data bits [7:0] and each higher address to the next higher byte. Bytes above the access width read as zero.
- R9: With host_rd and host_wr high together on a PROM access, the read returns the contents before the write, and the write takes effect at the clock edge.
- R10: host_size encodes 0 as a byte, 1 as 16 bits, 2 as 32 bits and 3 as reserved. A reserved access reads 0xFFFFFFFF, strobes nothing and writes nothing.
- R11: host_rdata is zero in any cycle where host_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| host_addr | input | 8 | Byte address of the host access within the selected window |
| host_size | input | 2 | Access size code: 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| host_mem | input | 1 | Window select: 0 I/O window, 1 memory window |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data, little-endian lanes |
| host_rdata | output | 32 | Read data, valid in the same cycle as host_rd |
| prom_wr_en | input | 1 | Allows PROM writes when high |
| dword_io | input | 1 | I/O window access mode: 0 byte/16-bit, 1 32-bit |
| port_addr | output | 8 | Address forwarded to the register port |
| port_size | output | 2 | Size code forwarded to the register port |
| port_wdata | output | 32 | Write data forwarded to the register port |
| port_rd | output | 1 | Register port read strobe |
| port_wr | output | 1 | Register port write strobe |
| port_rdata | input | 32 | Register port read data, returned in the same cycle |

## Verification
A PROM read and a PROM write can happen in the same cycle when the host raises both strobes on one PROM access. The bench provokes this with a byte access in the I/O window while the write enable is high. It checks that the read data in that cycle still shows the old byte. It then reads the same byte in the next cycle and checks that the new value is there.

// File: rtl/addr_prom_pkg.sv
package addr_prom_pkg;

  localparam int HOST_LANES = 4;
  localparam int HOST_DW    = HOST_LANES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PROM = 2'd1,
    TGT_PORT = 2'd2
  } acc_tgt_e;

  // Byte lanes covered by an access; the reserved code covers all lanes so
  // that its all-ones read spans the full bus.
  function automatic logic [HOST_LANES-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = HOST_LANES'(1);
      SZ_HALF: lane_mask = HOST_LANES'(3);
      default: lane_mask = '1;
    endcase
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_d;
  logic [1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/access_decode.sv
module access_decode
  import addr_prom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  input  logic                  mem_win,
  input  logic                  dword_io,
  output acc_tgt_e              tgt,
  output logic [IDX_W-1:0]      base,
  output logic [ADDR_W-1:0]     fwd_addr,
  output logic [HOST_LANES-1:0] lanes
);
  logic lo_win;
  logic wide;
  logic io_ok;

  always_comb begin
    lo_win   = (addr[ADDR_W-1:IDX_W] == '0);
    wide     = (size == SZ_HALF) || (size == SZ_WORD);
    io_ok    = 1'b0;
    tgt      = TGT_NONE;
    base     = addr[IDX_W-1:0];
    fwd_addr = addr;
    lanes    = lane_mask(size);

    if (mem_win) begin
      if (addr[IDX_W]) begin
        if (wide) begin
          tgt      = TGT_PORT;
          fwd_addr = ADDR_W'(addr[IDX_W-1:0]);
        end
      end else if (size != SZ_RSV) begin
        tgt = TGT_PROM;
      end
    end else if (lo_win) begin
      if (dword_io) begin
        io_ok = (size == SZ_WORD) && (addr[1:0] == 2'b00);
      end else begin
        io_ok = (size == SZ_BYTE) || ((size == SZ_HALF) && !addr[0]);
      end
      if (io_ok) begin
        tgt = TGT_PROM;
      end
    end else if (wide) begin
      tgt = TGT_PORT;
    end
  end
endmodule

// File: rtl/prom_bank.sv
module prom_bank
  import addr_prom_pkg::*;
#(
  parameter int                    BYTES = 16,
  parameter logic [BYTES*8-1:0]    INIT  = '0,
  localparam int                   IDX_W = $clog2(BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      base,
  input  logic [HOST_LANES-1:0] lane_we,
  input  logic [HOST_DW-1:0]    wdata,
  output logic [HOST_DW-1:0]    rdata,
  output logic [BYTES*8-1:0]    image
);
  logic [7:0] mem_q [BYTES];
  logic [7:0] mem_d [BYTES];
  logic       mem_en;

  always_comb begin
    mem_d  = mem_q;
    mem_en = |lane_we;
    for (int k = 0; k < HOST_LANES; k++) begin
      if (lane_we[k]) begin
        mem_d[base + IDX_W'(k)] = wdata[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) begin
        mem_q[i] <= INIT[8*i +: 8];
      end
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  for (genvar k = 0; k < HOST_LANES; k++) begin : g_rd_lane
    localparam logic [IDX_W-1:0] OFF = IDX_W'(k);
    assign rdata[8*k +: 8] = mem_q[base + OFF];
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_image
    assign image[8*i +: 8] = mem_q[i];
  end
endmodule

// File: rtl/addr_prom_front.sv
module addr_prom_front
  import addr_prom_pkg::*;
#(
  parameter int                          ADDR_W     = 8,
  parameter int                          PROM_BYTES = 16,
  parameter logic [PROM_BYTES*8-1:0]     PROM_INIT  =
    128'h5757_0000_0000_0000_0000_5634_1200_5452
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [1:0]          host_size,
  input  logic                host_mem,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [HOST_DW-1:0]  host_wdata,
  output logic [HOST_DW-1:0]  host_rdata,
  input  logic                prom_wr_en,
  input  logic                dword_io,
  output logic [ADDR_W-1:0]   port_addr,
  output logic [1:0]          port_size,
  output logic [HOST_DW-1:0]  port_wdata,
  output logic                port_rd,
  output logic                port_wr,
  input  logic [HOST_DW-1:0]  port_rdata
);
  localparam int IDX_W = $clog2(PROM_BYTES);

  logic                  rst_q;
  acc_tgt_e              tgt;
  logic [IDX_W-1:0]      base;
  logic [HOST_LANES-1:0] lanes;
  logic [HOST_LANES-1:0] lane_we;
  logic [HOST_DW-1:0]    ones;
  logic [HOST_DW-1:0]    prom_rdata;
  logic [PROM_BYTES*8-1:0] prom_image;
  logic [HOST_DW-1:0]    rd_mux;

  rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  access_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr     (host_addr),
    .size     (host_size),
    .mem_win  (host_mem),
    .dword_io (dword_io),
    .tgt      (tgt),
    .base     (base),
    .fwd_addr (port_addr),
    .lanes    (lanes)
  );

  prom_bank #(.BYTES(PROM_BYTES), .INIT(PROM_INIT)) u_prom (
    .clk     (clk),
    .rst_n   (rst_q),
    .base    (base),
    .lane_we (lane_we),
    .wdata   (host_wdata),
    .rdata   (prom_rdata),
    .image   (prom_image)
  );

  for (genvar k = 0; k < HOST_LANES; k++) begin : g_ones
    assign ones[8*k +: 8] = {8{lanes[k]}};
  end

  always_comb begin
    lane_we = (host_wr && prom_wr_en && (tgt == TGT_PROM)) ? lanes : '0;
    case (tgt)
      TGT_PROM: rd_mux = prom_rdata & ones;
      TGT_PORT: rd_mux = port_rdata & ones;
      default:  rd_mux = ones;
    endcase
    host_rdata = host_rd ? rd_mux : '0;
  end

  assign port_rd    = host_rd && (tgt == TGT_PORT);
  assign port_wr    = host_wr && (tgt == TGT_PORT);
  assign port_size  = host_size;
  assign port_wdata = host_wdata;

  // R2
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !prom_wr_en |=> $stable(prom_image));

  // R5
  port_wide_only_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (port_rd || port_wr) |-> (host_size == SZ_HALF || host_size == SZ_WORD));

  // R6
  mmio_byte_hi_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_mem && host_size == SZ_BYTE && host_addr[IDX_W])
      |-> (!port_rd && !port_wr && (!host_rd || host_rdata == 32'h0000_00FF)));

  // R6
  mmio_port_addr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_mem && (port_rd || port_wr)) |-> (port_addr[ADDR_W-1:IDX_W] == '0));

  // R4
  dword_bad_ones_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!host_mem && dword_io && host_rd && host_addr[ADDR_W-1:IDX_W] == '0 &&
     (host_size != SZ_WORD || host_addr[1:0] != 2'b00))
      |-> (host_rdata == ((host_size == SZ_BYTE) ? 32'h0000_00FF :
                          (host_size == SZ_HALF) ? 32'h0000_FFFF : 32'hFFFF_FFFF)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !host_rd |-> (host_rdata == '0));
endmodule

// File: tb/tb_addr_prom_front.sv
module tb_addr_prom_front;
  localparam logic [127:0] INIT = 128'h5757_0000_0000_0000_0000_5634_1200_5452;

  logic        clk;
  logic        rst_n;
  logic [7:0]  host_addr;
  logic [1:0]  host_size;
  logic        host_mem;
  logic        host_rd;
  logic        host_wr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        prom_wr_en;
  logic        dword_io;
  logic [7:0]  port_addr;
  logic [1:0]  port_size;
  logic [31:0] port_wdata;
  logic        port_rd;
  logic        port_wr;
  logic [31:0] port_rdata;

  int n_chk;
  int n_fail;
  logic [7:0] sh [16];

  addr_prom_front dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_size(host_size),
    .host_mem(host_mem), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .prom_wr_en(prom_wr_en),
    .dword_io(dword_io), .port_addr(port_addr), .port_size(port_size),
    .port_wdata(port_wdata), .port_rd(port_rd), .port_wr(port_wr),
    .port_rdata(port_rdata)
  );

  // Register port stub answering in the same cycle.
  assign port_rdata = {8'hC3, 8'h3C, ~port_addr, port_addr};

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_prom(input int b, input int n);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = sh[(b + k) & 15];
    return v;
  endfunction

  task automatic model_wr(input int b, input int n, input logic [31:0] d);
    for (int k = 0; k < n; k++) sh[(b + k) & 15] = d[8*k +: 8];
  endtask

  task automatic drive(input logic m, input logic [1:0] sz, input logic [7:0] a,
                       input logic r, input logic w, input logic [31:0] wd);
    @(negedge clk);
    host_mem = m; host_size = sz; host_addr = a;
    host_rd = r; host_wr = w; host_wdata = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; host_rd = 0; host_wr = 0; host_mem = 0; host_size = 0;
    host_addr = 0; host_wdata = 0; prom_wr_en = 0; dword_io = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 16; i++) sh[i] = INIT[8*i +: 8];
    #1;
    check("R11 idle read data", host_rdata, 32'h0);
    for (int i = 0; i < 16; i++) begin
      drive(0, 2'd0, 8'(i), 1, 0, 0);
      check("R1 reset PROM byte", host_rdata, {24'h0, INIT[8*i +: 8]});
    end
    idle();
  endtask

  task automatic t_we_gate();
    prom_wr_en = 0;
    drive(0, 2'd0, 8'h03, 0, 1, 32'hAA);
    drive(0, 2'd0, 8'h03, 1, 0, 0);
    check("R2 write dropped without enable", host_rdata, exp_prom(3, 1));
    prom_wr_en = 1;
    drive(0, 2'd0, 8'h03, 0, 1, 32'hAA);
    model_wr(3, 1, 32'hAA);
    drive(0, 2'd0, 8'h03, 1, 0, 0);
    check("R2 write taken with enable", host_rdata, 32'hAA);
    idle();
  endtask

  task automatic t_io_narrow();
    dword_io = 0; prom_wr_en = 1;
    drive(0, 2'd1, 8'h04, 1, 0, 0);
    check("R3 even 16-bit PROM read", host_rdata, exp_prom(4, 2));
    drive(0, 2'd1, 8'h06, 0, 1, 32'hBEEF);
    model_wr(6, 2, 32'hBEEF);
    drive(0, 2'd0, 8'h06, 1, 0, 0);
    check("R8 low lane at low address", host_rdata, 32'hEF);
    drive(0, 2'd0, 8'h07, 1, 0, 0);
    check("R8 high lane at next address", host_rdata, 32'hBE);
    drive(0, 2'd1, 8'h05, 1, 0, 0);
    check("R3 odd 16-bit reads ones", host_rdata, 32'h0000FFFF);
    drive(0, 2'd1, 8'h05, 0, 1, 32'h1111);
    drive(0, 2'd1, 8'h04, 1, 0, 0);
    check("R3 odd 16-bit write ignored", host_rdata, exp_prom(4, 2));
    drive(0, 2'd2, 8'h00, 1, 0, 0);
    check("R3 32-bit in narrow mode reads ones", host_rdata, 32'hFFFFFFFF);
    check("R3 no port strobe", {31'h0, port_rd}, 32'h0);
    idle();
  endtask

  task automatic t_io_dword();
    dword_io = 1; prom_wr_en = 1;
    drive(0, 2'd2, 8'h00, 1, 0, 0);
    check("R4 aligned 32-bit read", host_rdata, exp_prom(0, 4));
    drive(0, 2'd2, 8'h08, 0, 1, 32'hDDCCBBAA);
    model_wr(8, 4, 32'hDDCCBBAA);
    drive(0, 2'd2, 8'h08, 1, 0, 0);
    check("R4 aligned 32-bit write", host_rdata, 32'hDDCCBBAA);
    drive(0, 2'd0, 8'h08, 1, 0, 0);
    check("R4 byte reads ones", host_rdata, 32'h000000FF);
    drive(0, 2'd1, 8'h08, 1, 0, 0);
    check("R4 16-bit reads ones", host_rdata, 32'h0000FFFF);
    drive(0, 2'd2, 8'h02, 1, 0, 0);
    check("R4 misaligned 32-bit reads ones", host_rdata, 32'hFFFFFFFF);
    drive(0, 2'd2, 8'h0A, 0, 1, 32'h12345678);
    drive(0, 2'd2, 8'h08, 1, 0, 0);
    check("R4 misaligned write ignored lo", host_rdata, exp_prom(8, 4));
    drive(0, 2'd2, 8'h0C, 1, 0, 0);
    check("R4 misaligned write ignored hi", host_rdata, exp_prom(12, 4));
    dword_io = 0;
    idle();
  endtask

  task automatic t_io_port();
    drive(0, 2'd1, 8'h20, 1, 0, 0);
    check("R5 port read strobe", {31'h0, port_rd}, 32'h1);
    check("R5 port address unchanged", {24'h0, port_addr}, 32'h20);
    check("R5 port size", {30'h0, port_size}, 32'h1);
    check("R5 port read data masked", host_rdata, 32'h0000DF20);
    drive(0, 2'd2, 8'h14, 0, 1, 32'h5555AAAA);
    check("R5 port write strobe", {31'h0, port_wr}, 32'h1);
    check("R5 port write data", port_wdata, 32'h5555AAAA);
    check("R5 port write address", {24'h0, port_addr}, 32'h14);
    drive(0, 2'd0, 8'h20, 1, 0, 0);
    check("R5 byte at port offset no strobe", {31'h0, port_rd}, 32'h0);
    check("R5 byte at port offset reads ones", host_rdata, 32'h000000FF);
    idle();
  endtask

  task automatic t_mmio();
    prom_wr_en = 1;
    drive(1, 2'd1, 8'h1A, 1, 0, 0);
    check("R6 mmio port address masked", {24'h0, port_addr}, 32'h0A);
    check("R6 mmio port read data", host_rdata, 32'h0000F50A);
    drive(1, 2'd0, 8'h13, 1, 0, 0);
    check("R6 mmio byte high reads ones", host_rdata, 32'h000000FF);
    check("R6 mmio byte high no read strobe", {31'h0, port_rd}, 32'h0);
    drive(1, 2'd0, 8'h13, 0, 1, 32'h99);
    check("R6 mmio byte high no write strobe", {31'h0, port_wr}, 32'h0);
    drive(1, 2'd2, 8'h0E, 1, 0, 0);
    check("R7 mmio 32-bit wraps", host_rdata, exp_prom(14, 4));
    drive(1, 2'd2, 8'h0D, 0, 1, 32'h04030201);
    model_wr(13, 4, 32'h04030201);
    drive(0, 2'd0, 8'h00, 1, 0, 0);
    check("R7 wrapped write lands at byte 0", host_rdata, 32'h04);
    drive(1, 2'd1, 8'h03, 1, 0, 0);
    check("R7 mmio odd 16-bit PROM read", host_rdata, exp_prom(3, 2));
    idle();
  endtask

  task automatic t_both();
    logic [31:0] old;
    prom_wr_en = 1;
    old = exp_prom(9, 1);
    drive(0, 2'd0, 8'h09, 1, 1, 32'h77);
    check("R9 read shows old byte", host_rdata, old);
    model_wr(9, 1, 32'h77);
    drive(0, 2'd0, 8'h09, 1, 0, 0);
    check("R9 write committed", host_rdata, 32'h77);
    idle();
  endtask

  task automatic t_rsv();
    prom_wr_en = 1;
    drive(0, 2'd3, 8'h00, 1, 0, 0);
    check("R10 reserved size io reads ones", host_rdata, 32'hFFFFFFFF);
    drive(1, 2'd3, 8'h10, 1, 0, 0);
    check("R10 reserved size mmio reads ones", host_rdata, 32'hFFFFFFFF);
    check("R10 reserved size no strobe", {31'h0, port_rd}, 32'h0);
    drive(1, 2'd3, 8'h00, 0, 1, 32'hFFFFFFFF);
    drive(0, 2'd0, 8'h00, 1, 0, 0);
    check("R10 reserved write ignored", host_rdata, exp_prom(0, 1));
    idle();
    check("R11 idle read data after traffic", host_rdata, 32'h0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    t_we_gate();
    t_io_narrow();
    t_io_dword();
    t_io_port();
    t_mmio();
    t_both();
    t_rsv();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule